// File: doc/BRIEF.md
# Exception and Interrupt Entry Sequencer

This block sits between a processor's execute stage and its fetch unit. It decides what happens at the moment an exception or a hardware interrupt is taken. Each event is offered to it as one beat on a valid/ready input. The beat carries:
- any pending exception code, the interrupt request with its level and vector code;
- the live status word, program counter, vector base and stack pointer;
- the delay-slot flags.

The block arbitrates between the exception and the interrupt. A blocked exception becomes a reset. The block then returns one result beat holding:
- the redirect address and the new status word;
- saved copies of the program counter, status word and stack pointer;
- the class of the entry taken.

Two code registers keep the most recent exception code and the most recent interrupt vector code. They hold until another entry of their own kind is taken.

An accepted event that takes nothing produces no result beat. This covers an interrupt that is masked or blocked, and a beat that carries no request. On the input side `ev_ready` is high whenever the result register is empty or is being drained in the same cycle. While a result waits with `out_ready` low, the result stays unchanged and no new event is accepted.

Top module: `exc_entry_seq`

## Requirements
- R1: When an exception and a qualifying interrupt arrive in the same beat, the exception is taken (`out_kind` 1 or 0) and `intevt` is left unchanged.
- R2: With status bit 28 (block) set, any exception code other than 0x1E0 is taken as reset code 0x000. Code 0x1E0 is taken normally, to vector base + 0x100, with `expevt` = 0x1E0.
- R3: With status bit 28 set and no exception, an interrupt request produces no result beat and leaves `intevt` unchanged.
- R4: An interrupt is taken only when its level is strictly greater than status bits 7:4. An equal or lower level, or no request at all, produces no result beat.
- R5: On every entry, `out_ssr` equals the input status word and `out_sgr` equals the input stack pointer. `out_sr` is the input status word with bits 28, 29 and 30 set and all other bits kept, except as stated in R6.
- R6: Exception codes 0x000 and 0x020 are reset entries (`out_kind` 0). The redirect is 0xA0000000, and status bits 7:4 of `out_sr` are forced to 0xF.
- R7: Exception codes 0x040 and 0x060 redirect to vector base + 0x400. Every other non-reset exception (`out_kind` 1) redirects to vector base + 0x100.
- R8: A taken interrupt (`out_kind` 2) redirects to vector base + 0x600, writes its vector code to `intevt`, and leaves `expevt` unchanged.
- R9: A taken exception writes its effective code to `expevt`. For trap code 0x160, `out_spc` is the input program counter plus 2.
- R10: When either delay-slot flag is set, `out_spc` is the input program counter minus 2, with the trap correction of R9 then added, so a trap in a delay slot saves the program counter unchanged.
- R11: A result beat appears in the cycle after the event is accepted. While `out_ready` is low, `out_valid` and all result fields stay stable and `ev_ready` stays low.
- R12: After reset, `out_valid` is 0, `ev_ready` is 1, and `expevt` and `intevt` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_valid | input | 1 | Event beat offered |
| ev_ready | output | 1 | Event beat can be accepted |
| exc_valid | input | 1 | An exception is pending |
| exc_code | input | 12 | Exception code |
| irq_req | input | 1 | Hardware interrupt pending |
| irq_lvl | input | 4 | Level of the highest pending interrupt |
| irq_code | input | 12 | Vector code of that interrupt |
| cur_sr | input | 32 | Current status word |
| cur_pc | input | 32 | Current program counter |
| cur_vbr | input | 32 | Vector base |
| cur_r15 | input | 32 | Current stack pointer |
| ds_flags | input | 2 | Delay-slot flags (either set means in a delay slot) |
| out_valid | output | 1 | Result beat valid |
| out_ready | input | 1 | Result beat accepted |
| out_pc | output | 32 | Redirect address |
| out_sr | output | 32 | New status word |
| out_spc | output | 32 | Saved program counter |
| out_ssr | output | 32 | Saved status word |
| out_sgr | output | 32 | Saved stack pointer |
| out_kind | output | 2 | 0 reset, 1 exception, 2 interrupt |
| expevt | output | 12 | Last exception code taken |
| intevt | output | 12 | Last interrupt vector code taken |

## Verification
The bench targets the following corner cases and the faults each one exposes:

- **Equal interrupt level.** A design using a greater-or-equal compare would produce a spurious interrupt beat.
- **Simultaneous exception and interrupt.** A design with the wrong priority would take the interrupt and overwrite `intevt`.
- **Block bit set, with code 0x1E0 and with another code.** A design that ignores the block bit would jump to the vector base instead of the reset address. A design that forgets the 0x1E0 exemption would reset on it.
- **Trap inside a delay slot.** The two program-counter corrections must cancel. A design that applies only one of them would save an address off by 2.
- **Result held under back-pressure.** A design that ignores `out_ready` would lose the beat or accept a second event.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;
  localparam int CODE_W     = 12;
  localparam int LVL_W      = 4;
  localparam int SR_BL      = 28;
  localparam int SR_RB      = 29;
  localparam int SR_MD      = 30;
  localparam int SR_MASK_LO = 4;

  typedef enum logic [1:0] {
    KIND_RESET = 2'd0,
    KIND_EXC   = 2'd1,
    KIND_INT   = 2'd2
  } kind_e;

  localparam logic [CODE_W-1:0] CODE_POWERON   = 12'h000;
  localparam logic [CODE_W-1:0] CODE_MANUAL    = 12'h020;
  localparam logic [CODE_W-1:0] CODE_TLB_RD    = 12'h040;
  localparam logic [CODE_W-1:0] CODE_TLB_WR    = 12'h060;
  localparam logic [CODE_W-1:0] CODE_TRAP      = 12'h160;
  localparam logic [CODE_W-1:0] CODE_UNBLOCKED = 12'h1E0;

  localparam logic [31:0] RESET_PC    = 32'hA000_0000;
  localparam logic [31:0] OFF_GENERAL = 32'h0000_0100;
  localparam logic [31:0] OFF_TLB     = 32'h0000_0400;
  localparam logic [31:0] OFF_IRQ     = 32'h0000_0600;
endpackage

// File: rtl/exc_entry_arb.sv
module exc_entry_arb
  import exc_entry_pkg::*;
(
  input  logic              exc_valid,
  input  logic [CODE_W-1:0] exc_code,
  input  logic              irq_req,
  input  logic [LVL_W-1:0]  irq_lvl,
  input  logic              sr_bl,
  input  logic [LVL_W-1:0]  sr_mask,
  output logic              take,
  output kind_e             kind,
  output logic [CODE_W-1:0] eff_code
);
  logic blocked;
  logic irq_ok;
  logic is_reset;

  always_comb begin
    // a blocked exception other than the exempt code becomes a reset
    blocked  = exc_valid && sr_bl && (exc_code != CODE_UNBLOCKED);
    eff_code = blocked ? CODE_POWERON : exc_code;
    irq_ok   = irq_req && !sr_bl && (irq_lvl > sr_mask);
    is_reset = (eff_code == CODE_POWERON) || (eff_code == CODE_MANUAL);
    take     = exc_valid || irq_ok;
    if (exc_valid) kind = is_reset ? KIND_RESET : KIND_EXC;
    else           kind = KIND_INT;
  end
endmodule

// File: rtl/exc_entry_vec.sv
module exc_entry_vec
  import exc_entry_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  kind_e             kind,
  input  logic [CODE_W-1:0] eff_code,
  input  logic [XLEN-1:0]   vbr,
  input  logic [XLEN-1:0]   sr_in,
  output logic [XLEN-1:0]   target,
  output logic [XLEN-1:0]   sr_out
);
  logic tlb_class;

  always_comb begin
    tlb_class = (eff_code == CODE_TLB_RD) || (eff_code == CODE_TLB_WR);
    unique case (kind)
      KIND_RESET: target = XLEN'(RESET_PC);
      KIND_INT:   target = vbr + XLEN'(OFF_IRQ);
      default:    target = vbr + (tlb_class ? XLEN'(OFF_TLB) : XLEN'(OFF_GENERAL));
    endcase
    sr_out        = sr_in;
    sr_out[SR_BL] = 1'b1;
    sr_out[SR_RB] = 1'b1;
    sr_out[SR_MD] = 1'b1;
    if (kind == KIND_RESET) sr_out[SR_MASK_LO +: LVL_W] = '1;
  end
endmodule

// File: rtl/exc_entry_ctx.sv
module exc_entry_ctx
  import exc_entry_pkg::*;
#(
  parameter int XLEN       = 32,
  parameter int DS_W       = 2,
  parameter int INSN_BYTES = 2
) (
  input  logic [XLEN-1:0]   pc,
  input  logic [DS_W-1:0]   ds_flags,
  input  kind_e             kind,
  input  logic [CODE_W-1:0] eff_code,
  output logic [XLEN-1:0]   spc
);
  localparam logic [XLEN-1:0] STEP = XLEN'(INSN_BYTES);

  logic in_slot;
  logic is_trap;

  always_comb begin
    in_slot = |ds_flags;
    is_trap = (kind == KIND_EXC) && (eff_code == CODE_TRAP);
    spc = pc;
    if (in_slot) spc = spc - STEP;   // re-execute the branch
    if (is_trap) spc = spc + STEP;   // return past the trap
  end
endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
  import exc_entry_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int DS_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_valid,
  output logic              ev_ready,
  input  logic              exc_valid,
  input  logic [CODE_W-1:0] exc_code,
  input  logic              irq_req,
  input  logic [LVL_W-1:0]  irq_lvl,
  input  logic [CODE_W-1:0] irq_code,
  input  logic [XLEN-1:0]   cur_sr,
  input  logic [XLEN-1:0]   cur_pc,
  input  logic [XLEN-1:0]   cur_vbr,
  input  logic [XLEN-1:0]   cur_r15,
  input  logic [DS_W-1:0]   ds_flags,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [XLEN-1:0]   out_pc,
  output logic [XLEN-1:0]   out_sr,
  output logic [XLEN-1:0]   out_spc,
  output logic [XLEN-1:0]   out_ssr,
  output logic [XLEN-1:0]   out_sgr,
  output logic [1:0]        out_kind,
  output logic [CODE_W-1:0] expevt,
  output logic [CODE_W-1:0] intevt
);
  logic              take;
  kind_e             kind;
  logic [CODE_W-1:0] eff_code;
  logic [XLEN-1:0]   target;
  logic [XLEN-1:0]   sr_next;
  logic [XLEN-1:0]   spc_next;
  logic              accept;

  assign ev_ready = !out_valid || out_ready;
  assign accept   = ev_valid && ev_ready;

  exc_entry_arb u_arb (
    .exc_valid (exc_valid),
    .exc_code  (exc_code),
    .irq_req   (irq_req),
    .irq_lvl   (irq_lvl),
    .sr_bl     (cur_sr[SR_BL]),
    .sr_mask   (cur_sr[SR_MASK_LO +: LVL_W]),
    .take      (take),
    .kind      (kind),
    .eff_code  (eff_code)
  );

  exc_entry_vec #(.XLEN(XLEN)) u_vec (
    .kind     (kind),
    .eff_code (eff_code),
    .vbr      (cur_vbr),
    .sr_in    (cur_sr),
    .target   (target),
    .sr_out   (sr_next)
  );

  exc_entry_ctx #(.XLEN(XLEN), .DS_W(DS_W)) u_ctx (
    .pc       (cur_pc),
    .ds_flags (ds_flags),
    .kind     (kind),
    .eff_code (eff_code),
    .spc      (spc_next)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_pc    <= '0;
      out_sr    <= '0;
      out_spc   <= '0;
      out_ssr   <= '0;
      out_sgr   <= '0;
      out_kind  <= 2'd0;
      expevt    <= '0;
      intevt    <= '0;
    end else if (accept && take) begin
      out_valid <= 1'b1;
      out_pc    <= target;
      out_sr    <= sr_next;
      out_spc   <= spc_next;
      out_ssr   <= cur_sr;
      out_sgr   <= cur_r15;
      out_kind  <= kind;
      if (kind == KIND_INT) intevt <= irq_code;
      else                  expevt <= eff_code;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/exc_entry_seq_chk.sv
module exc_entry_seq_chk
  import exc_entry_pkg::*;
#(
  parameter int XLEN = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            ev_valid,
  input logic            ev_ready,
  input logic            exc_valid,
  input logic [XLEN-1:0] cur_sr,
  input logic [XLEN-1:0] cur_vbr,
  input logic            out_valid,
  input logic            out_ready,
  input logic [XLEN-1:0] out_pc,
  input logic [XLEN-1:0] out_sr,
  input logic [1:0]      out_kind
);
  // R11
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_pc) && $stable(out_sr));

  // R11
  rise_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(ev_valid && ev_ready));

  // R5
  sr_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_sr[SR_BL] && out_sr[SR_RB] && out_sr[SR_MD]);

  // R6
  reset_vector_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_kind == KIND_RESET |-> out_pc == XLEN'(RESET_PC) && (&out_sr[SR_MASK_LO +: LVL_W]));

  // R1
  exc_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_valid && ev_ready && exc_valid |=> out_valid && out_kind != KIND_INT);

  // R3
  blocked_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_valid && ev_ready && !exc_valid && cur_sr[SR_BL] |=> !out_valid);

  // R8
  irq_vector_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_valid && ev_ready && !exc_valid |=> !out_valid || out_pc == $past(cur_vbr) + XLEN'(OFF_IRQ));
endmodule

bind exc_entry_seq exc_entry_seq_chk #(.XLEN(XLEN)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ev_valid  (ev_valid),
  .ev_ready  (ev_ready),
  .exc_valid (exc_valid),
  .cur_sr    (cur_sr),
  .cur_vbr   (cur_vbr),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_pc    (out_pc),
  .out_sr    (out_sr),
  .out_kind  (out_kind)
);

// File: tb/exc_entry_seq_test.sv
module exc_entry_seq_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ev_valid = 1'b0;
  logic        ev_ready;
  logic        exc_valid = 1'b0;
  logic [11:0] exc_code = '0;
  logic        irq_req = 1'b0;
  logic [3:0]  irq_lvl = '0;
  logic [11:0] irq_code = '0;
  logic [31:0] cur_sr = '0, cur_pc = '0, cur_vbr = 32'h8C00_0000, cur_r15 = '0;
  logic [1:0]  ds_flags = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [31:0] out_pc, out_sr, out_spc, out_ssr, out_sgr;
  logic [1:0]  out_kind;
  logic [11:0] expevt, intevt;

  always #2.5 clk = ~clk;

  exc_entry_seq uut (.*);

  typedef struct packed {
    logic [31:0] pc, sr, spc, ssr, sgr;
    logic [1:0]  kind;
    logic [11:0] xe, ie;
  } exp_t;

  exp_t  q[$];
  string tq[$];
  int    checks = 0;
  int    fails = 0;
  logic [11:0] m_xe = '0, m_ie = '0;

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, expv);
    end
  endtask

  // monitor: compare each result beat against the queue
  always @(negedge clk) begin
    if (rst_n && out_valid && out_ready) begin
      checks++;
      if (q.size() == 0) begin
        fails++;
        $display("FAIL R4 unexpected beat act_pc=%h exp=none", out_pc);
      end else begin
        exp_t  e;
        string t;
        e = q.pop_front();
        t = tq.pop_front();
        if ({out_pc, out_sr, out_spc, out_ssr, out_sgr, out_kind, expevt, intevt} != e) begin
          fails++;
          $display("FAIL %s act pc=%h sr=%h spc=%h ssr=%h sgr=%h k=%0d xe=%h ie=%h exp pc=%h sr=%h spc=%h ssr=%h sgr=%h k=%0d xe=%h ie=%h",
                   t, out_pc, out_sr, out_spc, out_ssr, out_sgr, out_kind, expevt, intevt,
                   e.pc, e.sr, e.spc, e.ssr, e.sgr, e.kind, e.xe, e.ie);
        end
      end
    end
  end

  task automatic send(input logic ev, input logic [11:0] code, input logic irq, input logic [3:0] lvl,
                      input logic [11:0] vec, input logic [31:0] sr, input logic [31:0] pc,
                      input logic [1:0] ds, input string tag);
    exp_t        e;
    logic        take = 1'b0;
    logic [11:0] ec = code;
    logic [1:0]  k = 2'd0;
    logic [31:0] tgt = '0;
    @(posedge clk); #1;
    ev_valid = 1'b1; exc_valid = ev; exc_code = code; irq_req = irq; irq_lvl = lvl;
    irq_code = vec; cur_sr = sr; cur_pc = pc; cur_r15 = pc ^ 32'h0F0F_0000; ds_flags = ds;
    while (!ev_ready) begin @(posedge clk); #1; end
    if (ev) begin
      if (sr[28] && code != 12'h1E0) ec = 12'h000;
      take = 1'b1;
      k = (ec == 12'h000 || ec == 12'h020) ? 2'd0 : 2'd1;
      if (k == 2'd0) tgt = 32'hA000_0000;
      else if (ec == 12'h040 || ec == 12'h060) tgt = cur_vbr + 32'h400;
      else tgt = cur_vbr + 32'h100;
      m_xe = ec;
    end else if (irq && !sr[28] && lvl > sr[7:4]) begin
      take = 1'b1; k = 2'd2; tgt = cur_vbr + 32'h600; m_ie = vec;
    end
    if (take) begin
      e.pc  = tgt;
      e.sr  = sr | 32'h7000_0000;
      if (k == 2'd0) e.sr[7:4] = 4'hF;
      e.spc = pc - ((ds != 2'd0) ? 32'd2 : 32'd0) + ((k == 2'd1 && ec == 12'h160) ? 32'd2 : 32'd0);
      e.ssr = sr; e.sgr = pc ^ 32'h0F0F_0000; e.kind = k; e.xe = m_xe; e.ie = m_ie;
      q.push_back(e); tq.push_back(tag);
    end
    @(posedge clk); #1;
    ev_valid = 1'b0;
    if (take) chk(out_valid == 1'b1, {tag, " R11 beat one cycle after accept"}, {31'd0, out_valid}, 32'd1);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog act=hung exp=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin : main
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R12 reset state
    chk(out_valid == 1'b0, "R12 out_valid", {31'd0, out_valid}, 32'd0);
    chk(ev_ready == 1'b1, "R12 ev_ready", {31'd0, ev_ready}, 32'd1);
    chk(expevt == 12'h0 && intevt == 12'h0, "R12 codes", {8'd0, expevt, intevt}, 32'd0);
    @(posedge clk); #1; rst_n = 1'b1;

    send(1, 12'h180, 0, 4'd0, 12'h0, 32'h0000_0030, 32'h0C00_1000, 2'd0, "R7 R9 general");
    send(1, 12'h040, 0, 4'd0, 12'h0, 32'h0000_0030, 32'h0C00_2000, 2'd0, "R7 tlb read");
    send(1, 12'h060, 0, 4'd0, 12'h0, 32'h0000_0030, 32'h0C00_2004, 2'd0, "R7 tlb write");
    send(1, 12'h020, 0, 4'd0, 12'h0, 32'h0000_0030, 32'h0C00_3000, 2'd0, "R6 manual reset");
    send(1, 12'h000, 0, 4'd0, 12'h0, 32'h0000_0000, 32'h0C00_3010, 2'd0, "R6 power reset");
    send(1, 12'h160, 0, 4'd0, 12'h0, 32'h0000_0030, 32'h0C00_4000, 2'd0, "R9 trap");
    send(1, 12'h180, 0, 4'd0, 12'h0, 32'h0000_0030, 32'h0C00_5000, 2'd1, "R10 delay slot");
    send(1, 12'h160, 0, 4'd0, 12'h0, 32'h0000_0030, 32'h0C00_5100, 2'd2, "R10 trap in slot");
    send(0, 12'h000, 1, 4'd5, 12'h320, 32'h0000_0030, 32'h0C00_6000, 2'd0, "R8 interrupt");
    send(0, 12'h000, 1, 4'd9, 12'h3A0, 32'h0000_0080, 32'h0C00_6100, 2'd3, "R8 R10 irq in slot");

    send(0, 12'h000, 1, 4'd3, 12'h400, 32'h0000_0030, 32'h0C00_7000, 2'd0, "R4 equal level");
    send(0, 12'h000, 1, 4'd1, 12'h420, 32'h0000_0030, 32'h0C00_7010, 2'd0, "R4 lower level");
    send(0, 12'h000, 0, 4'd9, 12'h440, 32'h0000_0030, 32'h0C00_7020, 2'd0, "R4 no request");
    repeat (2) @(negedge clk);
    chk(out_valid == 1'b0, "R4 no beat", {31'd0, out_valid}, 32'd0);
    chk(intevt == m_ie, "R4 intevt held", {20'd0, intevt}, {20'd0, m_ie});

    send(1, 12'h1A0, 1, 4'd15, 12'h500, 32'h0000_0010, 32'h0C00_8000, 2'd0, "R1 exc over irq");
    @(negedge clk);
    chk(intevt == m_ie, "R1 intevt held", {20'd0, intevt}, {20'd0, m_ie});

    send(1, 12'h180, 0, 4'd0, 12'h0, 32'h1000_0030, 32'h0C00_9000, 2'd0, "R2 blocked to reset");
    send(1, 12'h1E0, 0, 4'd0, 12'h0, 32'h1000_0030, 32'h0C00_9100, 2'd0, "R2 exempt code");
    send(0, 12'h000, 1, 4'd14, 12'h520, 32'h1000_0030, 32'h0C00_9200, 2'd0, "R3 blocked irq");
    repeat (2) @(negedge clk);
    chk(out_valid == 1'b0, "R3 no beat", {31'd0, out_valid}, 32'd0);
    chk(intevt == m_ie, "R3 intevt held", {20'd0, intevt}, {20'd0, m_ie});

    send(1, 12'h0E0, 0, 4'd0, 12'h0, 32'h0F0F_0301, 32'h0C00_A000, 2'd0, "R5 sr bits kept");

    // R11 back-pressure
    @(posedge clk); #1; out_ready = 1'b0;
    send(1, 12'h100, 0, 4'd0, 12'h0, 32'h0000_0030, 32'h0C00_B000, 2'd0, "R11 stalled beat");
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(out_valid && !ev_ready, "R11 hold under stall", {30'd0, out_valid, ev_ready}, 32'd2);
    end
    @(posedge clk); #1; out_ready = 1'b1;
    send(0, 12'h000, 1, 4'd7, 12'h600, 32'h0000_0020, 32'h0C00_C000, 2'd0, "R11 after stall");

    repeat (4) @(negedge clk);
    chk(q.size() == 0, "R11 all beats seen", q.size(), 32'd0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule